// File: doc/BRIEF.md
# System Clock Divider with PLL Clamping

This block turns a source clock into a system clock enable, plus a 50% duty divided clock, using an even divisor. The divisor comes from a 4-bit code held in a 32-bit run-mode configuration word. The same word holds a divider-use bit and a PWM divider-enable bit. Choosing between the PLL output and the reference clock, and muxing the two without glitches, happen outside this block. Here `clk_i` is the clock already chosen, and `bypass_i` says whether that clock is the PLL (0) or the reference (1).

While the PLL is the source, the divider is always used. Any code below a minimum is raised to that minimum, and the configuration word reads back the raised code, not the one written. While the reference is the source, every code is allowed. If the divider-use bit is also clear, the enable is high on every cycle. A new divisor is picked up only at the end of the period in progress, so no short period can appear.

Top module: `sysclk_div_ctrl`

## Requirements
- R1: After reset the word reads 0x07C00000: code 0xF in bits 26:23, divider-use bit 22 set, all other bits clear. `pwm_div_en_o` is low and the divisor is 32.
- R2: While the divider is used, `sys_en_o` pulses high for one cycle once every N cycles, where N = 2*(code+1). Two pulses are never on back-to-back cycles.
- R3: While `bypass_i`=0 the divider is used even if bit 22 is clear.
- R4: While `bypass_i`=0, a stored code below MIN_CODE (default 3) divides by 2*(MIN_CODE+1), which is 8 by default.
- R5: Bits 26:23 of `rd_data_o` show the code actually in use. This is the raised code while `bypass_i`=0, and the stored code while `bypass_i`=1. Changing only `bypass_i` changes the read-back in the same cycle.
- R6: While `bypass_i`=1, codes below MIN_CODE are used as written: code 1 divides by 4 and code 0 divides by 2.
- R7: While `bypass_i`=1 and bit 22 is clear, `sys_en_o` is high on every cycle and `sys_clk_o` stays low.
- R8: A new divisor takes effect at the next terminal count. The period already in progress finishes at the old length.
- R9: In each period of N cycles, `sys_clk_o` is high for the first N/2 cycles and low for the remaining N/2.
- R10: Bit 20 can be written and read back, and it drives `pwm_div_en_o`. Bit 21 and every bit outside 26:20 read as 0, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Selected source clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bypass_i | input | 1 | 0: PLL is the source, 1: reference is the source |
| wr_en_i | input | 1 | Write strobe for the configuration word |
| wr_data_i | input | 32 | Configuration word to write |
| rd_data_o | output | 32 | Configuration word read-back, showing the code in use |
| sys_en_o | output | 1 | System clock enable pulse |
| sys_clk_o | output | 1 | Divided clock, 50% duty |
| pwm_div_en_o | output | 1 | PWM divider enable |

## Verification
The assertions check four things on every cycle. The read-back code never drops below the minimum while the PLL is the source. Enable pulses are never adjacent while dividing. The counter steps by one and keeps its latched divisor until the terminal count. The enable stays high whenever the divider is unused on the reference clock. Only the bench scenarios can show the rest. These are the actual period lengths and duty for each code, the clamp as seen in the period length, and a divisor change that lets the old period finish. They also cover read-back when only `bypass_i` flips, and how the reserved bits behave.

// File: rtl/sysdiv_pkg.sv
package sysdiv_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned CODE_LSB = 23;
  localparam int unsigned USE_BIT  = 22;
  localparam int unsigned RSVD_BIT = 21;
  localparam int unsigned PWM_BIT  = 20;
endpackage

// File: rtl/sysdiv_cfg_reg.sv
module sysdiv_cfg_reg
  import sysdiv_pkg::*;
#(
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned MIN_CODE = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bypass_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic [CODE_W-1:0] eff_code_o,
  output logic              active_o,
  output logic              pwm_en_o
);
  localparam logic [CODE_W-1:0] MinCode  = CODE_W'(MIN_CODE);
  localparam logic [CODE_W-1:0] ResetCode = '1;

  logic [CODE_W-1:0] code_q;
  logic              use_q;
  logic              pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= ResetCode;
      use_q  <= 1'b1;
      pwm_q  <= 1'b0;
    end else if (wr_en_i) begin
      code_q <= wr_data_i[CODE_LSB +: CODE_W];
      use_q  <= wr_data_i[USE_BIT];
      pwm_q  <= wr_data_i[PWM_BIT];
    end
  end

  // clamp only while PLL sources the clock; stored value is kept as written
  always_comb begin
    eff_code_o = code_q;
    if (!bypass_i && code_q < MinCode) eff_code_o = MinCode;
  end

  assign active_o = use_q | ~bypass_i;
  assign pwm_en_o = pwm_q;

  always_comb begin
    rd_data_o                        = '0;
    rd_data_o[CODE_LSB +: CODE_W]    = eff_code_o;
    rd_data_o[USE_BIT]               = use_q;
    rd_data_o[PWM_BIT]               = pwm_q;
  end
endmodule

// File: rtl/sysdiv_counter.sv
module sysdiv_counter #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              en_o,
  output logic              sys_clk_o
);
  localparam int unsigned CNT_W = CODE_W + 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] cur_q;
  logic              tc;

  // divisor 2*(code+1): terminal count is 2*code+1
  assign tc = (cnt_q == {cur_q, 1'b1});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cur_q <= '1;
    end else if (!active_i || tc) begin
      cnt_q <= '0;
      cur_q <= code_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign en_o      = ~active_i | tc;
  assign sys_clk_o = active_i & (cnt_q <= {1'b0, cur_q});

  assert_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !tc) |=> cnt_q == $past(cnt_q) + 1'b1);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !tc) |=> $stable(cur_q));

  assert_no_b2b_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && en_o) |=> (!active_i || !en_o));
endmodule

// File: rtl/sysclk_div_ctrl.sv
module sysclk_div_ctrl
  import sysdiv_pkg::*;
#(
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned MIN_CODE = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bypass_i,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        sys_en_o,
  output logic        sys_clk_o,
  output logic        pwm_div_en_o
);
  logic [CODE_W-1:0] eff_code;
  logic              active;

  sysdiv_cfg_reg #(.CODE_W(CODE_W), .MIN_CODE(MIN_CODE)) i_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bypass_i   (bypass_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .rd_data_o  (rd_data_o),
    .eff_code_o (eff_code),
    .active_o   (active),
    .pwm_en_o   (pwm_div_en_o)
  );

  sysdiv_counter #(.CODE_W(CODE_W)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .code_i    (eff_code),
    .en_o      (sys_en_o),
    .sys_clk_o (sys_clk_o)
  );

  assert_clamp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bypass_i |-> rd_data_o[CODE_LSB +: CODE_W] >= CODE_W'(MIN_CODE));

  assert_full_rate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_i && !rd_data_o[USE_BIT]) |-> (sys_en_o && !sys_clk_o));
endmodule

// File: tb/test_sysclk_div_ctrl.sv
module test_sysclk_div_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bypass = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        sys_en, sys_clk, pwm_en;

  int n_chk = 0, n_fail = 0;
  int exp_n[$];
  string exp_tag[$];
  event pulse_ev;
  int cyc = 0, hi = 0;

  always #10 clk = ~clk;

  sysclk_div_ctrl i_sysclk_div_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bypass_i(bypass), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .sys_en_o(sys_en),
    .sys_clk_o(sys_clk), .pwm_div_en_o(pwm_en));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: measure each period and its high time, compare against queue
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (sys_clk) hi++;
      if (sys_en) begin
        if (exp_n.size() != 0) begin
          int e;
          string t;
          e = exp_n.pop_front();
          t = exp_tag.pop_front();
          check(cyc == e, {t, " period"}, cyc, e);
          check(hi == e / 2, "R9 high time", hi, e / 2);
        end
        cyc = 0;
        hi = 0;
        -> pulse_ev;
      end
    end
  end

  function automatic logic [31:0] word(input int code, input bit use_div, input bit pwm);
    return (32'(code) << 23) | (32'(use_div) << 22) | (32'(pwm) << 20);
  endfunction

  // driver: apply config away from a pulse, then expect periods
  task automatic run(input logic [31:0] d, input bit byp, input bit do_wr,
                     input int old_n, input int new_n, input int cnt, input string tag);
    @(negedge clk);
    for (int k = 0; k < 64 && sys_en; k++) @(negedge clk);
    if (old_n != 0) begin exp_n.push_back(old_n); exp_tag.push_back("R8"); end
    bypass = byp;
    if (do_wr) begin wr_en = 1'b1; wr_data = d; end
    @(negedge clk);
    wr_en = 1'b0;
    @(pulse_ev);
    for (int k = 0; k < cnt; k++) begin exp_n.push_back(new_n); exp_tag.push_back(tag); end
    wait (exp_n.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data == 32'h07C0_0000, "R1 reset word", rd_data, 32'h07C0_0000);
    check(pwm_en == 1'b0, "R1 pwm reset", pwm_en, 0);
    @(pulse_ev);
    for (int k = 0; k < 2; k++) begin exp_n.push_back(32); exp_tag.push_back("R1"); end
    wait (exp_n.size() == 0);

    run(word(5, 1, 0), 1'b1, 1'b1, 32, 12, 3, "R2");
    // PLL source, code below min, use bit clear: forced and clamped to /8
    run(word(1, 0, 0), 1'b0, 1'b1, 12, 8, 3, "R4");
    check(rd_data[26:23] == 4'd3, "R5 clamped readback", rd_data[26:23], 3);
    run(word(7, 0, 0), 1'b0, 1'b1, 8, 16, 2, "R3");

    // reference source, divider unused: full rate
    @(negedge clk);
    for (int k = 0; k < 64 && sys_en; k++) @(negedge clk);
    bypass = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      check(sys_en == 1'b1, "R7 enable every cycle", sys_en, 1);
      check(sys_clk == 1'b0, "R7 divided clock low", sys_clk, 0);
      @(negedge clk);
    end
    check(rd_data[26:23] == 4'd7, "R5 raw readback", rd_data[26:23], 7);

    run(word(1, 1, 0), 1'b1, 1'b1, 0, 4, 3, "R6");
    check(rd_data[26:23] == 4'd1, "R5 unclamped readback", rd_data[26:23], 1);
    run(word(0, 1, 0), 1'b1, 1'b1, 4, 2, 4, "R6");
    // only bypass flips: code 0 now clamped
    run('0, 1'b0, 1'b0, 2, 8, 2, "R4");
    check(rd_data[26:23] == 4'd3, "R5 readback on bypass flip", rd_data[26:23], 3);
    bypass = 1'b1;
    #1;
    check(rd_data[26:23] == 4'd0, "R5 readback after bypass back", rd_data[26:23], 0);

    run(word(9, 1, 1) | 32'h0020_FFFF | 32'hF800_0000, 1'b1, 1'b1, 0, 20, 2, "R10");
    check(rd_data == word(9, 1, 1), "R10 reserved bits", rd_data, word(9, 1, 1));
    check(pwm_en == 1'b1, "R10 pwm enable", pwm_en, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule